// File: doc/BRIEF.md
# Reconfigurable Transposed-Form FIR Filter

This block is a 16-tap finite impulse response filter built in transposed direct form. Each accepted sample is presented to all taps in the same cycle. A single shared multiple bank forms every small multiple of the current sample (0x to 7x) once. Every tap then builds its coefficient product from that bank using only multiplexers, fixed shifts and adders, with no general multiplier anywhere.

The taps take their coefficients from a two-level table. Software-side writes land in a staging copy at any time. The staging copy moves into the active copy on the clock edge that accepts a sample. This lets a new filter response be loaded while the stream keeps running: every sample's products are formed from one consistent coefficient set.

Partial sums travel down a chain of delay registers. The registered output carries y[n] one cycle after the sample is accepted.

Top module: `tdf_fir_reconfig`

## Requirements
- R1: `out_vld` is high in exactly the cycle after a cycle with `in_vld` high, and low in every other cycle.
- R2: Data formats are as follows. Samples and coefficients are signed two's-complement 16-bit values, and `out_y` is a signed 36-bit value. The value registered with a sample n is the sum over k = 0..15 of c_n-k[k] * x[n-k], where x[n-k] is the sample accepted k samples earlier. The delay chain starts from zero.
- R3: Reset (synchronous, active high) clears the output, the output valid, every delay register and both coefficient copies to zero. Samples sent before any coefficient is loaded therefore produce 0.
- R4: In a cycle without `in_vld`, `out_y` keeps its previous value.
- R5: A write with `cw_en` high stores `cw_data` into the staging entry for tap `cw_addr` (address k selects tap k, the tap that weights x[n-k]). The active set is replaced by the staging set at every edge that accepts a sample, and a write in that same cycle is included. The sample accepted at that edge still uses the set that was active before the edge. A write alone never changes `out_y`.
- R6: After a reload, products already in the delay chain keep the set that was in force when their sample arrived. Each term c_m[k] uses the set that was active for sample m.
- R7: Products and sums are exact at the extremes, including coefficient -32768 and sample -32768, with no wrap.
- R8: With a committed set, an impulse of amplitude A followed by zeros produces A*c[0], A*c[1], ..., A*c[15] on successive samples, then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample accepted this cycle |
| in_x | input | 16 | Signed input sample |
| cw_en | input | 1 | Coefficient staging write enable |
| cw_addr | input | 4 | Tap index of the write |
| cw_data | input | 16 | Signed coefficient value |
| out_vld | output | 1 | Output sample valid |
| out_y | output | 36 | Signed filter output |

## Verification
The bound checker watches four properties on every clock:
- the one-cycle valid pipeline;
- the output hold when no sample arrives;
- the cleared state after reset;
- the rule that the active coefficient set moves only on a sample edge.

Only the bench's scenarios can show that the arithmetic is right. A behavioural convolution model keeps a history of samples and, for each one, the coefficient snapshot that was active when it arrived. The scenarios are:
- an impulse and a step;
- random data with idle gaps;
- a reload done partway through the stream, including a write in the same cycle as a sample;
- full-scale negative operands.

Because of the per-sample snapshots, the mixed old/new outputs after a reload are predicted exactly.

// File: rtl/fir_csm_pkg.sv
package fir_csm_pkg;

  // Integer ceiling division used to size group counts.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Width of the signed multiples m*x for m in [0, 2**gw).
  function automatic int mult_width(input int xw, input int gw);
    return xw + gw;
  endfunction

  // Full-precision accumulator width for ntaps products of xw x cw.
  function automatic int acc_width(input int xw, input int cw, input int ntaps);
    return xw + cw + $clog2(ntaps);
  endfunction

endpackage

// File: rtl/fir_mult_bank.sv
// Shared multiple bank: forms m*x for every m in [0, 2**GW) once.
// Even multiples are shifts of a smaller one; odd ones cost one adder.
module fir_mult_bank #(
  parameter int XW = 16,
  parameter int GW = 3,
  localparam int NM = 1 << GW,
  localparam int BW = fir_csm_pkg::mult_width(XW, GW)
) (
  input  logic signed [XW-1:0]   x,
  output logic        [NM*BW-1:0] mult_flat
);

  for (genvar m = 0; m < NM; m++) begin : g_mul
    logic signed [BW-1:0] v;
    if (m == 0) begin : g_zero
      assign v = '0;
    end else if (m == 1) begin : g_one
      assign v = {{GW{x[XW-1]}}, x};
    end else if ((m % 2) == 0) begin : g_even
      assign v = g_mul[m/2].v <<< 1;
    end else begin : g_odd
      assign v = g_mul[m-1].v + g_mul[1].v;
    end
    assign mult_flat[m*BW +: BW] = v;
  end

endmodule

// File: rtl/fir_tap_pe.sv
// One tap: coefficient product from shared multiples, muxes and fixed shifts.
// Magnitude bits are taken GW at a time; the sign bit subtracts x << (CW-1).
module fir_tap_pe #(
  parameter int XW = 16,
  parameter int CW = 16,
  parameter int GW = 3,
  localparam int NM = 1 << GW,
  localparam int BW = fir_csm_pkg::mult_width(XW, GW),
  localparam int PW = XW + CW,
  localparam int NG = fir_csm_pkg::ceil_div(CW - 1, GW),
  localparam int MW = NG * GW
) (
  input  logic        [CW-1:0]    coef,
  input  logic signed [XW-1:0]    x,
  input  logic        [NM*BW-1:0] mult_flat,
  output logic signed [PW-1:0]    prod
);

  logic [MW-1:0] mag;
  assign mag = MW'(coef[CW-2:0]);

  logic signed [PW-1:0] term [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GW-1:0]        sel;
    logic signed [BW-1:0] pick;
    assign sel  = mag[g*GW +: GW];
    assign pick = mult_flat[sel*BW +: BW];
    assign term[g] = {{(PW-BW){pick[BW-1]}}, pick} <<< (g*GW);
  end

  logic signed [PW-1:0] pos_sum;
  logic signed [PW-1:0] neg_term;

  always_comb begin
    pos_sum = '0;
    for (int g = 0; g < NG; g++) pos_sum = pos_sum + term[g];
  end

  assign neg_term = coef[CW-1] ? ({{CW{x[XW-1]}}, x} <<< (CW-1)) : '0;
  assign prod     = pos_sum - neg_term;

endmodule

// File: rtl/fir_coef_table.sv
// Staging and active coefficient copies; active loads on commit.
module fir_coef_table #(
  parameter int NTAPS = 16,
  parameter int CW    = 16,
  localparam int AW   = $clog2(NTAPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [CW-1:0]         wr_data,
  input  logic                  commit,
  output logic [NTAPS*CW-1:0]   act_flat
);

  logic [CW-1:0] stage_q [NTAPS];
  logic [CW-1:0] act_q   [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) begin
        stage_q[i] <= '0;
        act_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NTAPS; i++) begin
        if (wr_en && wr_addr == AW'(i)) stage_q[i] <= wr_data;
        if (commit)
          act_q[i] <= (wr_en && wr_addr == AW'(i)) ? wr_data : stage_q[i];
      end
    end
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_out
    assign act_flat[i*CW +: CW] = act_q[i];
  end

endmodule

// File: rtl/fir_tdf_chain.sv
// Transposed-form delay and adder chain; advances only on accepted samples.
module fir_tdf_chain #(
  parameter int NTAPS = 16,
  parameter int PW    = 32,
  parameter int ACCW  = 36
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic [NTAPS*PW-1:0]   prod_flat,
  output logic signed [ACCW-1:0] y,
  output logic                  y_vld
);

  logic signed [ACCW-1:0] ext [NTAPS];
  logic signed [ACCW-1:0] z_q [NTAPS-1];

  for (genvar k = 0; k < NTAPS; k++) begin : g_ext
    logic signed [PW-1:0] p;
    assign p      = prod_flat[k*PW +: PW];
    assign ext[k] = {{(ACCW-PW){p[PW-1]}}, p};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS-1; k++) z_q[k] <= '0;
      y     <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= adv;
      if (adv) begin
        for (int k = 0; k < NTAPS-2; k++) z_q[k] <= ext[k+1] + z_q[k+1];
        z_q[NTAPS-2] <= ext[NTAPS-1];
        y <= ext[0] + z_q[0];
      end
    end
  end

endmodule

// File: rtl/tdf_fir_reconfig.sv
module tdf_fir_reconfig #(
  parameter int NTAPS = 16,
  parameter int XW    = 16,
  parameter int CW    = 16,
  parameter int GW    = 3,
  localparam int AW   = $clog2(NTAPS),
  localparam int NM   = 1 << GW,
  localparam int BW   = fir_csm_pkg::mult_width(XW, GW),
  localparam int PW   = XW + CW,
  localparam int ACCW = fir_csm_pkg::acc_width(XW, CW, NTAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [XW-1:0]   in_x,
  input  logic            cw_en,
  input  logic [AW-1:0]   cw_addr,
  input  logic [CW-1:0]   cw_data,
  output logic            out_vld,
  output logic [ACCW-1:0] out_y
);

  // Named internal events for the checker.
  logic                    commit_w;
  logic [NTAPS*CW-1:0]     act_flat;
  logic [NM*BW-1:0]        mult_flat;
  logic [NTAPS*PW-1:0]     prod_flat;
  logic signed [ACCW-1:0]  y_s;

  assign commit_w = in_vld;

  fir_coef_table #(.NTAPS(NTAPS), .CW(CW)) u_table (
    .clk(clk), .rst(rst), .wr_en(cw_en), .wr_addr(cw_addr),
    .wr_data(cw_data), .commit(commit_w), .act_flat(act_flat)
  );

  fir_mult_bank #(.XW(XW), .GW(GW)) u_bank (
    .x($signed(in_x)), .mult_flat(mult_flat)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_pe
    logic signed [PW-1:0] p;
    fir_tap_pe #(.XW(XW), .CW(CW), .GW(GW)) u_pe (
      .coef(act_flat[k*CW +: CW]), .x($signed(in_x)),
      .mult_flat(mult_flat), .prod(p)
    );
    assign prod_flat[k*PW +: PW] = p;
  end

  fir_tdf_chain #(.NTAPS(NTAPS), .PW(PW), .ACCW(ACCW)) u_chain (
    .clk(clk), .rst(rst), .adv(in_vld), .prod_flat(prod_flat),
    .y(y_s), .y_vld(out_vld)
  );

  assign out_y = y_s;

endmodule

// File: rtl/tdf_fir_reconfig_chk.sv
module tdf_fir_reconfig_chk #(
  parameter int YW = 36,
  parameter int TW = 256
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          out_vld,
  input logic [YW-1:0] out_y,
  input logic          commit_w,
  input logic [TW-1:0] act_flat
);

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_y == '0 && !out_vld));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_y));

  // R5
  table_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_w |=> $stable(act_flat));

endmodule

bind tdf_fir_reconfig tdf_fir_reconfig_chk #(.YW(ACCW), .TW(NTAPS*CW)) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .out_vld(out_vld),
  .out_y(out_y), .commit_w(commit_w), .act_flat(act_flat)
);

// File: tb/tdf_fir_reconfig_tb_top.sv
module tdf_fir_reconfig_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int YW = 36;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [15:0] in_x = '0;
  logic        cw_en = 1'b0;
  logic [3:0]  cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic        out_vld;
  logic [YW-1:0] out_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdf_fir_reconfig dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .out_vld(out_vld), .out_y(out_y)
  );

  typedef longint coefv_t [N];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  coefv_t act_m, stg_m, set_a, set_b;
  longint hx[$];
  coefv_t hh[$];
  longint exp_y = 0;
  bit     exp_v = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint model_sum();
    longint s = 0;
    for (int k = 0; k < hx.size(); k++) s += hh[k][k] * hx[k];
    return s;
  endfunction

  // One cycle: drive, update model at the edge, check after it.
  task automatic step(input bit v, input longint x, input bit we, input int a,
                      input longint d, input string tag);
    in_vld  = v;
    in_x    = 16'(x);
    cw_en   = we;
    cw_addr = 4'(a);
    cw_data = 16'(d);
    @(posedge clk);
    if (v) begin
      hx.push_front(x);
      hh.push_front(act_m);
      if (hx.size() > N) begin
        void'(hx.pop_back());
        void'(hh.pop_back());
      end
      exp_y = model_sum();
    end
    if (we) stg_m[a] = d;
    if (v) act_m = stg_m;
    exp_v = v;
    @(negedge clk);
    chk(out_vld == exp_v, "R1 out_vld", longint'(out_vld), longint'(exp_v));
    chk(longint'($signed(out_y)) == exp_y, v ? tag : "R4 hold",
        longint'($signed(out_y)), exp_y);
  endtask

  function automatic longint rnd16();
    return longint'($signed(16'($urandom)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) begin
      act_m[i] = 0;
      stg_m[i] = 0;
      set_a[i] = longint'((i * 7919 + 311) % 20000) - 10000;
      set_b[i] = rnd16();
    end

    // R3: reset state
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_vld == 1'b0, "R3 reset vld", longint'(out_vld), 0);
    chk(out_y == '0, "R3 reset y", longint'($signed(out_y)), 0);
    rst = 1'b0;

    // R3: tables cleared, so early samples give zero
    step(1, 1234, 0, 0, 0, "R3 zero table");
    step(1, -77, 0, 0, 0, "R3 zero table");

    // R5: staging writes alone leave the output unchanged
    for (int i = 0; i < N; i++) step(0, 0, 1, i, set_a[i], "R5");

    // R2: commit with flush of zeros
    for (int i = 0; i < N; i++) step(1, 0, 0, 0, 0, "R2 flush");

    // R8: impulse response
    step(1, 1000, 0, 0, 0, "R8 impulse");
    for (int i = 0; i < N + 3; i++) step(1, 0, 0, 0, 0, "R8 impulse tail");

    // R2: step input
    for (int i = 0; i < N + 8; i++) step(1, 300, 0, 0, 0, "R2 step");

    // R2: random data with idle gaps
    for (int i = 0; i < 60; i++) begin
      step(1, rnd16(), 0, 0, 0, "R2 random");
      if (($urandom % 4) == 0) step(0, 0, 0, 0, 0, "R4");
    end

    // R5/R6: reload partway through, last write shares a sample cycle
    for (int i = 0; i < N - 1; i++) begin
      step(0, 0, 1, i, set_b[i], "R5");
      step(1, rnd16(), 0, 0, 0, "R5 staged not active");
    end
    step(1, rnd16(), 1, N - 1, set_b[N-1], "R5 same-cycle write");
    for (int i = 0; i < 40; i++) step(1, rnd16(), 0, 0, 0, "R6 reload transition");

    // R7: extreme operands
    for (int i = 0; i < N; i++)
      step(0, 0, 1, i, (i % 2 == 0) ? -32768 : 32767, "R5");
    step(1, -32768, 0, 0, 0, "R7 commit");
    for (int i = 0; i < N + 6; i++)
      step(1, (i % 3 == 2) ? 32767 : -32768, 0, 0, 0, "R7 extremes");
    for (int i = 0; i < N; i++) step(0, 0, 1, i, -32768, "R5");
    for (int i = 0; i < N + 2; i++) step(1, -32768, 0, 0, 0, "R7 all negative");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule